// File: doc/BRIEF.md
# I2C Controller Byte FIFO with Threshold Flags

This block is the single byte buffer of an I2C master controller. Transmit and receive traffic share it. The host side pushes and pops bytes through a data register. The bus side belongs to the protocol sequencer, which exchanges bytes through two valid/ready streams: one into the FIFO and one out of it. The block keeps the read and write pointers and the fill level. It also holds the two 6-bit thresholds taken from a buffer-configuration write.

From these the block raises a set of flags:
- A receive "ready" flag above the receive threshold, and a "draining" flag for the tail at or below it.
- The same ready/draining pair on the transmit side, evaluated when the sequencer empties the FIFO.
- An access-complete flag.
- A sticky host access-error flag.
- A transmit underflow flag.
- A receive overrun flag.

A 16-bit buffer-status word reports the configured depth, the fill level and the remaining transfer count.

Back-pressure on the bus streams works as follows. At most one byte enters and at most one byte leaves per cycle, and the host has priority on both.
- `bus_in_ready` is high only when the FIFO is not full, no host write is strobed and no clear is requested. The sequencer must hold `bus_in_data` while `bus_in_ready` is low.
- `bus_out_valid` is high only when the FIFO is not empty, no host read is strobed and no clear is requested. `bus_out_data` is the head byte.

Host accesses never stall. An access that cannot complete is dropped, and the access-error flag is raised instead.

Top module: `i2c_byte_fifo`

## Requirements
- R1: Bytes leave in the order they entered. `host_rd_data` and `bus_out_data` both show the head byte whenever the FIFO is not empty, and `buf_status[13:8]` shows the fill level modulo 64.
- R2: Per cycle, at most one push occurs (a host write, else a bus push) and at most one pop occurs (a host read, else a bus pop). `bus_in_ready` = not full and not `host_wr` and not clear. `bus_out_valid` = not empty and not `host_rd` and not clear. A push and a pop in the same cycle leave the level unchanged, and the level never exceeds DEPTH.
- R3: After a bus push, `rx_ready` = 1 and `rx_drain` = 0 if the new level exceeds the receive threshold. Otherwise `rx_ready` = 0 and `rx_drain` = 1. This rule takes precedence over R4 in the same cycle.
- R4: After a successful host read with no bus push in that cycle:
  - a new level of 0 clears `rx_ready` and `rx_drain` and sets `xfer_done`;
  - a non-zero new level at or below the receive threshold clears `rx_ready` and sets `rx_drain`;
  - any other new level leaves both flags unchanged.
  Any successful push clears `xfer_done`.
- R5: A host read of an empty FIFO or a host write to a full FIFO sets `acc_err` and changes no data. A successful host access clears `acc_err`, and setting wins over clearing.
- R6: `tx_underflow` sets when `bus_out_ready` is high, the FIFO is empty, `xfer_left` is non-zero and no host write is strobed. A successful host write clears it.
- R7: A successful host write clears `tx_ready` and `tx_drain`. When a bus pop leaves the FIFO empty:
  - if `xfer_left` is 0, both flags clear and `xfer_done` sets;
  - otherwise `tx_ready` = (`xfer_left` > transmit threshold) and `tx_drain` is its inverse.
- R8: `rx_overrun` sets when `bus_in_valid` is high while the FIFO is full. A successful host read clears it, and setting wins over clearing.
- R9: A configuration write with bit 14 or bit 6 set is a clear. It empties the FIFO and clears `rx_ready`, `rx_drain`, `tx_ready` and `tx_drain`. Every push, pop and flag event in that cycle is ignored.
- R10: `buf_status` = {depth code, level[5:0], 2'b00, `xfer_left`}. The depth code is 00 for 8, 01 for 16, 10 for 32 and 11 for 64.
- R11: After reset the FIFO is empty, both thresholds are 0 and every flag is 0. A configuration write loads the receive threshold from bits [13:8] and the transmit threshold from bits [5:0], taking effect from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_wr | input | 1 | Host data-register write strobe |
| host_wr_data | input | 8 | Host write byte |
| host_rd | input | 1 | Host data-register read strobe |
| host_rd_data | output | 8 | Head byte, returned by a host read |
| cfg_we | input | 1 | Buffer-configuration write strobe |
| cfg_wdata | input | 16 | Configuration word: [13:8] rx threshold, [5:0] tx threshold, 14/6 clear |
| xfer_left | input | 6 | Remaining transfer count from the sequencer |
| bus_in_valid | input | 1 | Sequencer offers a received byte |
| bus_in_data | input | 8 | Received byte |
| bus_in_ready | output | 1 | FIFO accepts the offered byte |
| bus_out_valid | output | 1 | Head byte available for transmission |
| bus_out_data | output | 8 | Byte to transmit |
| bus_out_ready | input | 1 | Sequencer takes the byte (or requests one) |
| rx_ready | output | 1 | Receive level above threshold |
| rx_drain | output | 1 | Receive tail at or below threshold |
| tx_ready | output | 1 | Transmit refill needed, count above threshold |
| tx_drain | output | 1 | Transmit tail at or below threshold |
| xfer_done | output | 1 | Access complete |
| acc_err | output | 1 | Sticky host access error |
| tx_underflow | output | 1 | Sequencer wanted a byte from an empty FIFO |
| rx_overrun | output | 1 | Byte offered while full |
| buf_status | output | 16 | Buffer-status word |

## Verification
Two pairs of functions can fall in the same cycle, and the bench targets both.
- A host write and a bus pop: the bench drives them together at level 1 and expects the level to stay at 1 while the old head leaves.
- A host read and a bus push: the bench drives them together with the receive threshold at 0. The push rule must set `rx_ready`, where the read rule alone would have left it clear.

A behavioural queue model is compared with every output on every cycle. This covers both collisions and a long random mix of clears, strobes and stream traffic.

// File: rtl/i2cfifo_pkg.sv
package i2cfifo_pkg;

  localparam int unsigned THR_W = 6;
  localparam int unsigned CNT_W = 6;
  localparam int unsigned BYTE_W = 8;

  // Per-cycle events the top hands to the flag logic.
  typedef struct packed {
    logic flush;      // clear request wins over all else
    logic bus_push;   // byte accepted from the sequencer
    logic bus_pop;    // byte taken by the sequencer
    logic host_rd_ok; // host read of a non-empty FIFO
    logic host_wr_ok; // host write to a non-full FIFO
    logic host_bad;   // host access that could not complete
    logic bus_ovf;    // byte offered while full
    logic udf_hit;    // sequencer asked for data, FIFO empty
  } fifo_evt_t;

  function automatic logic [1:0] depth_code(input int unsigned depth);
    case (depth)
      16:      return 2'b01;
      32:      return 2'b10;
      64:      return 2'b11;
      default: return 2'b00;
    endcase
  endfunction

endpackage

// File: rtl/fifo_store.sv
module fifo_store #(
  parameter int unsigned DEPTH = 16,
  localparam int unsigned AW = $clog2(DEPTH),
  localparam int unsigned LW = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          push,
  input  logic [7:0]    push_data,
  input  logic          pop,
  output logic [7:0]    head_data,
  output logic [LW-1:0] fill,
  output logic [LW-1:0] fill_next
);

  logic [7:0]    mem [DEPTH];
  logic [AW-1:0] wr_ptr;
  logic [AW-1:0] rd_ptr;

  assign head_data = mem[rd_ptr];

  always_comb begin
    if (flush) fill_next = '0;
    else       fill_next = fill + LW'(push) - LW'(pop);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      fill   <= '0;
    end else if (flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      fill   <= '0;
    end else begin
      if (push) wr_ptr <= wr_ptr + AW'(1);
      if (pop)  rd_ptr <= rd_ptr + AW'(1);
      fill <= fill_next;
    end
  end

  always_ff @(posedge clk) begin
    if (push && !flush) mem[wr_ptr] <= push_data;
  end

endmodule

// File: rtl/fifo_flags.sv
module fifo_flags
  import i2cfifo_pkg::*;
#(
  parameter int unsigned LW = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  fifo_evt_t        evt,
  input  logic [LW-1:0]    fill_next,
  input  logic [THR_W-1:0] rx_thr,
  input  logic [THR_W-1:0] tx_thr,
  input  logic [CNT_W-1:0] xfer_left,
  output logic             rx_ready,
  output logic             rx_drain,
  output logic             tx_ready,
  output logic             tx_drain,
  output logic             xfer_done,
  output logic             acc_err,
  output logic             tx_underflow,
  output logic             rx_overrun
);

  logic [7:0] nxt8;
  logic [7:0] rthr8;
  logic [7:0] tthr8;
  logic [7:0] left8;
  logic       above_rx;
  logic       at_or_below_rx;
  logic       now_empty;
  logic       any_push;

  logic rrdy_n, rdr_n, xrdy_n, xdr_n, done_n, aerr_n, udf_n, ovr_n;

  assign nxt8           = 8'(fill_next);
  assign rthr8          = 8'(rx_thr);
  assign tthr8          = 8'(tx_thr);
  assign left8          = 8'(xfer_left);
  assign above_rx       = nxt8 > rthr8;
  assign at_or_below_rx = !above_rx;
  assign now_empty      = nxt8 == 8'd0;
  assign any_push       = evt.bus_push | evt.host_wr_ok;

  always_comb begin
    rrdy_n = rx_ready;
    rdr_n  = rx_drain;
    xrdy_n = tx_ready;
    xdr_n  = tx_drain;
    done_n = xfer_done;
    aerr_n = acc_err;
    udf_n  = tx_underflow;
    ovr_n  = rx_overrun;

    if (evt.flush) begin
      rrdy_n = 1'b0;
      rdr_n  = 1'b0;
      xrdy_n = 1'b0;
      xdr_n  = 1'b0;
    end else begin
      // receive side: bus push decides first, host read otherwise
      if (evt.bus_push) begin
        rrdy_n = above_rx;
        rdr_n  = !above_rx;
      end else if (evt.host_rd_ok) begin
        if (now_empty) begin
          rrdy_n = 1'b0;
          rdr_n  = 1'b0;
          done_n = 1'b1;
        end else if (at_or_below_rx) begin
          rrdy_n = 1'b0;
          rdr_n  = 1'b1;
        end
      end

      if (any_push) done_n = 1'b0;

      // transmit side
      if (evt.host_wr_ok) begin
        xrdy_n = 1'b0;
        xdr_n  = 1'b0;
        udf_n  = 1'b0;
      end
      if (evt.bus_pop && now_empty) begin
        if (xfer_left != '0) begin
          xrdy_n = left8 > tthr8;
          xdr_n  = !(left8 > tthr8);
        end else begin
          xrdy_n = 1'b0;
          xdr_n  = 1'b0;
          done_n = 1'b1;
        end
      end
      if (evt.udf_hit) udf_n = 1'b1;

      // host access error: set wins over clear
      if (evt.host_rd_ok || evt.host_wr_ok) aerr_n = 1'b0;
      if (evt.host_bad) aerr_n = 1'b1;

      // receive overrun: set wins over clear
      if (evt.host_rd_ok) ovr_n = 1'b0;
      if (evt.bus_ovf)    ovr_n = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_ready     <= 1'b0;
      rx_drain     <= 1'b0;
      tx_ready     <= 1'b0;
      tx_drain     <= 1'b0;
      xfer_done    <= 1'b0;
      acc_err      <= 1'b0;
      tx_underflow <= 1'b0;
      rx_overrun   <= 1'b0;
    end else begin
      rx_ready     <= rrdy_n;
      rx_drain     <= rdr_n;
      tx_ready     <= xrdy_n;
      tx_drain     <= xdr_n;
      xfer_done    <= done_n;
      acc_err      <= aerr_n;
      tx_underflow <= udf_n;
      rx_overrun   <= ovr_n;
    end
  end

endmodule

// File: rtl/fifo_status.sv
module fifo_status
  import i2cfifo_pkg::*;
#(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned LW = 5
) (
  input  logic [LW-1:0]    fill,
  input  logic [CNT_W-1:0] xfer_left,
  output logic [15:0]      word
);

  localparam logic [1:0] DCODE = depth_code(DEPTH);

  logic [7:0] fill8;

  assign fill8 = 8'(fill);
  assign word  = {DCODE, fill8[5:0], 2'b00, xfer_left};

endmodule

// File: rtl/i2c_byte_fifo.sv
module i2c_byte_fifo
  import i2cfifo_pkg::*;
#(
  parameter int unsigned DEPTH = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        host_wr,
  input  logic [7:0]  host_wr_data,
  input  logic        host_rd,
  output logic [7:0]  host_rd_data,
  input  logic        cfg_we,
  input  logic [15:0] cfg_wdata,
  input  logic [5:0]  xfer_left,
  input  logic        bus_in_valid,
  input  logic [7:0]  bus_in_data,
  output logic        bus_in_ready,
  output logic        bus_out_valid,
  output logic [7:0]  bus_out_data,
  input  logic        bus_out_ready,
  output logic        rx_ready,
  output logic        rx_drain,
  output logic        tx_ready,
  output logic        tx_drain,
  output logic        xfer_done,
  output logic        acc_err,
  output logic        tx_underflow,
  output logic        rx_overrun,
  output logic [15:0] buf_status
);

  localparam int unsigned AW = $clog2(DEPTH);
  localparam int unsigned LW = AW + 1;
  localparam logic [LW-1:0] FULL_LVL = LW'(DEPTH);

  logic [THR_W-1:0] rx_thr;
  logic [THR_W-1:0] tx_thr;
  logic [LW-1:0]    fill;
  logic [LW-1:0]    fill_next;
  logic [7:0]       head;
  logic             full, empty, flush;
  logic             push, pop;
  logic [7:0]       push_data;
  logic             cfg_unused;
  fifo_evt_t        evt;

  assign cfg_unused = ^{cfg_wdata[15], cfg_wdata[7]};

  assign full  = fill == FULL_LVL;
  assign empty = fill == '0;
  assign flush = cfg_we & (cfg_wdata[14] | cfg_wdata[6]);

  assign bus_in_ready  = !full  && !host_wr && !flush;
  assign bus_out_valid = !empty && !host_rd && !flush;
  assign bus_out_data  = head;
  assign host_rd_data  = head;

  always_comb begin
    evt            = '0;
    evt.flush      = flush;
    evt.host_wr_ok = host_wr && !full  && !flush;
    evt.host_rd_ok = host_rd && !empty && !flush;
    evt.host_bad   = !flush && ((host_wr && full) || (host_rd && empty));
    evt.bus_push   = bus_in_valid  && bus_in_ready;
    evt.bus_pop    = bus_out_valid && bus_out_ready;
    evt.bus_ovf    = bus_in_valid && full && !flush;
    evt.udf_hit    = bus_out_ready && empty && (xfer_left != '0) && !host_wr && !flush;
  end

  assign push      = evt.host_wr_ok | evt.bus_push;
  assign pop       = evt.host_rd_ok | evt.bus_pop;
  assign push_data = host_wr ? host_wr_data : bus_in_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_thr <= '0;
      tx_thr <= '0;
    end else if (cfg_we) begin
      rx_thr <= cfg_wdata[13:8];
      tx_thr <= cfg_wdata[5:0];
    end
  end

  fifo_store #(.DEPTH(DEPTH)) u_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .flush     (flush),
    .push      (push),
    .push_data (push_data),
    .pop       (pop),
    .head_data (head),
    .fill      (fill),
    .fill_next (fill_next)
  );

  fifo_flags #(.LW(LW)) u_flags (
    .clk          (clk),
    .rst_n        (rst_n),
    .evt          (evt),
    .fill_next    (fill_next),
    .rx_thr       (rx_thr),
    .tx_thr       (tx_thr),
    .xfer_left    (xfer_left),
    .rx_ready     (rx_ready),
    .rx_drain     (rx_drain),
    .tx_ready     (tx_ready),
    .tx_drain     (tx_drain),
    .xfer_done    (xfer_done),
    .acc_err      (acc_err),
    .tx_underflow (tx_underflow),
    .rx_overrun   (rx_overrun)
  );

  fifo_status #(.DEPTH(DEPTH), .LW(LW)) u_status (
    .fill      (fill),
    .xfer_left (xfer_left),
    .word      (buf_status)
  );

endmodule

// File: rtl/i2c_byte_fifo_chk.sv
module i2c_byte_fifo_chk #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned LW = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cfg_we,
  input logic [1:0]    clr_bits,
  input logic          host_rd,
  input logic          bus_in_valid,
  input logic [LW-1:0] fill,
  input logic          rx_ready,
  input logic          rx_drain,
  input logic          tx_ready,
  input logic          tx_drain,
  input logic          acc_err,
  input logic          rx_overrun
);

  logic clr;
  assign clr = cfg_we && (clr_bits != 2'b00);

  assert_no_overflow_R2: assert property (@(posedge clk) disable iff (!rst_n)
    fill <= LW'(DEPTH));

  assert_rx_exclusive_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(rx_ready && rx_drain));

  assert_tx_exclusive_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(tx_ready && tx_drain));

  assert_empty_read_err_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (host_rd && fill == '0 && !clr) |=> acc_err);

  assert_full_offer_ovr_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_in_valid && fill == LW'(DEPTH) && !clr) |=> rx_overrun);

  assert_clear_empties_R9: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (fill == '0 && !rx_ready && !rx_drain));

endmodule

bind i2c_byte_fifo i2c_byte_fifo_chk #(.DEPTH(DEPTH), .LW(LW)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .cfg_we       (cfg_we),
  .clr_bits     ({cfg_wdata[14], cfg_wdata[6]}),
  .host_rd      (host_rd),
  .bus_in_valid (bus_in_valid),
  .fill         (fill),
  .rx_ready     (rx_ready),
  .rx_drain     (rx_drain),
  .tx_ready     (tx_ready),
  .tx_drain     (tx_drain),
  .acc_err      (acc_err),
  .rx_overrun   (rx_overrun)
);

// File: tb/test_i2c_byte_fifo.sv
`timescale 1ns/1ps
module test_i2c_byte_fifo;
  localparam int D = 16;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        rst_n;
  logic        hw, hr, cwe, biv, bor;
  logic [7:0]  hwd, bid;
  logic [15:0] cwd;
  logic [5:0]  left;
  logic [7:0]  host_rd_data, bus_out_data;
  logic        bus_in_ready, bus_out_valid;
  logic        rx_ready, rx_drain, tx_ready, tx_drain, xfer_done;
  logic        acc_err, tx_underflow, rx_overrun;
  logic [15:0] buf_status;

  i2c_byte_fifo #(.DEPTH(D)) i_i2c_byte_fifo (
    .clk(clk), .rst_n(rst_n),
    .host_wr(hw), .host_wr_data(hwd), .host_rd(hr), .host_rd_data(host_rd_data),
    .cfg_we(cwe), .cfg_wdata(cwd), .xfer_left(left),
    .bus_in_valid(biv), .bus_in_data(bid), .bus_in_ready(bus_in_ready),
    .bus_out_valid(bus_out_valid), .bus_out_data(bus_out_data), .bus_out_ready(bor),
    .rx_ready(rx_ready), .rx_drain(rx_drain), .tx_ready(tx_ready), .tx_drain(tx_drain),
    .xfer_done(xfer_done), .acc_err(acc_err), .tx_underflow(tx_underflow),
    .rx_overrun(rx_overrun), .buf_status(buf_status)
  );

  int checks = 0;
  int errors = 0;

  // behavioural reference model
  logic [7:0] mq[$];
  int rthr = 0, tthr = 0;
  bit m_rrdy, m_rdr, m_xrdy, m_xdr, m_done, m_aerr, m_udf, m_ovr;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic model_step();
    int lvl, nl, nrt, ntt;
    bit clr, inr, outv, wok, wbad, rok, rbad, bpush, bpop;
    lvl = mq.size();
    nrt = rthr; ntt = tthr;
    clr = cwe && (cwd[14] || cwd[6]);
    if (cwe) begin nrt = int'(cwd[13:8]); ntt = int'(cwd[5:0]); end
    if (clr) begin
      mq.delete();
      m_rrdy = 0; m_rdr = 0; m_xrdy = 0; m_xdr = 0;
      rthr = nrt; tthr = ntt;
      return;
    end
    inr   = (lvl < D) && !hw;
    outv  = (lvl > 0) && !hr;
    wok   = hw && lvl < D;   wbad = hw && lvl == D;
    rok   = hr && lvl > 0;   rbad = hr && lvl == 0;
    bpush = biv && inr;
    bpop  = outv && bor;
    if (rok || bpop) void'(mq.pop_front());
    if (wok) mq.push_back(hwd);
    else if (bpush) mq.push_back(bid);
    nl = mq.size();
    if (bpush) begin
      m_rrdy = nl > rthr; m_rdr = !(nl > rthr);
    end else if (rok) begin
      if (nl == 0) begin m_rrdy = 0; m_rdr = 0; m_done = 1; end
      else if (nl <= rthr) begin m_rrdy = 0; m_rdr = 1; end
    end
    if (wok || bpush) m_done = 0;
    if (wok) begin m_xrdy = 0; m_xdr = 0; m_udf = 0; end
    if (bpop && nl == 0) begin
      if (left != 0) begin m_xrdy = int'(left) > tthr; m_xdr = !(int'(left) > tthr); end
      else begin m_xrdy = 0; m_xdr = 0; m_done = 1; end
    end
    if (bor && lvl == 0 && left != 0 && !hw) m_udf = 1;
    if (wok || rok) m_aerr = 0;
    if (wbad || rbad) m_aerr = 1;
    if (rok) m_ovr = 0;
    if (biv && lvl == D) m_ovr = 1;
    rthr = nrt; tthr = ntt;
  endtask

  task automatic compare_all();
    int lvl;
    bit clr;
    logic [15:0] st;
    lvl = mq.size();
    clr = cwe && (cwd[14] || cwd[6]);
    chk("R2 bus_in_ready",  bus_in_ready,  int'((lvl < D) && !hw && !clr));
    chk("R2 bus_out_valid", bus_out_valid, int'((lvl > 0) && !hr && !clr));
    if (lvl > 0) begin
      chk("R1 host_rd_data", host_rd_data, mq[0]);
      chk("R1 bus_out_data", bus_out_data, mq[0]);
    end
    chk("R3 R4 rx_ready", rx_ready, m_rrdy);
    chk("R3 R4 rx_drain", rx_drain, m_rdr);
    chk("R7 tx_ready", tx_ready, m_xrdy);
    chk("R7 tx_drain", tx_drain, m_xdr);
    chk("R4 R7 xfer_done", xfer_done, m_done);
    chk("R5 acc_err", acc_err, m_aerr);
    chk("R6 tx_underflow", tx_underflow, m_udf);
    chk("R8 rx_overrun", rx_overrun, m_ovr);
    st = {2'b01, 6'(lvl), 2'b00, left};
    chk("R10 buf_status", buf_status, st);
  endtask

  task automatic idle();
    hw = 0; hr = 0; cwe = 0; biv = 0; bor = 0;
  endtask

  task automatic step();
    @(posedge clk);
    model_step();
    @(negedge clk);
    compare_all();
    idle();
  endtask

  task automatic bus_push(input logic [7:0] b);
    biv = 1; bid = b; step();
  endtask

  task automatic host_write(input logic [7:0] b);
    hw = 1; hwd = b; step();
  endtask

  task automatic host_read();
    hr = 1; step();
  endtask

  task automatic cfg(input logic [15:0] v);
    cwe = 1; cwd = v; step();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    idle(); hwd = 0; bid = 0; cwd = 0; left = 0;
    rst_n = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    // r11_ reset state
    chk("R11 reset rx_ready", rx_ready, 0);
    chk("R11 reset acc_err", acc_err, 0);
    chk("R11 reset bus_out_valid", bus_out_valid, 0);
    chk("R11 reset status", buf_status, 16'h4000);
    compare_all();

    cfg(16'h0302);                  // rx thr 3, tx thr 2
    bus_push(8'hA0); bus_push(8'hA1); bus_push(8'hA2);
    chk("R3 level 3 not above thr", rx_drain, 1);
    bus_push(8'hA3);
    chk("R3 level 4 above thr", rx_ready, 1);
    host_read();
    chk("R4 tail at thr", rx_drain, 1);
    host_read(); host_read();
    chk("R1 order head", host_rd_data, 8'hA3);
    host_read();
    chk("R4 empty sets done", xfer_done, 1);

    host_read();
    chk("R5 empty read error", acc_err, 1);
    host_write(8'h11);
    chk("R5 good write clears error", acc_err, 0);

    // host write + bus pop at level 1
    hw = 1; hwd = 8'h22; bor = 1; step();
    chk("R2 push+pop level unchanged", buf_status[13:8], 1);
    chk("R1 new head after swap", bus_out_data, 8'h22);

    // host read + bus push at level 1, rx threshold 0
    cfg(16'h0002);
    hr = 1; biv = 1; bid = 8'h33; step();
    chk("R3 bus push rule wins", rx_ready, 1);

    // fill to full
    for (int i = 0; i < D - 1; i++) host_write(8'(i));
    chk("R2 full no ready", bus_in_ready, 0);
    host_write(8'hEE);
    chk("R5 full write error", acc_err, 1);
    biv = 1; bid = 8'h44; step();
    chk("R8 overrun on full", rx_overrun, 1);
    host_read();
    chk("R8 read clears overrun", rx_overrun, 0);

    cfg(16'h4302);
    chk("R9 clear rx empties", buf_status[13:8], 0);

    // transmit side
    left = 6'd5;
    host_write(8'h51); host_write(8'h52);
    bor = 1; step(); bor = 1; step();
    chk("R7 count above tx thr", tx_ready, 1);
    left = 6'd2;
    host_write(8'h53);
    chk("R7 write clears tx_ready", tx_ready, 0);
    bor = 1; step();
    chk("R7 count at tx thr", tx_drain, 1);
    left = 6'd0;
    host_write(8'h54); bor = 1; step();
    chk("R7 zero count done", xfer_done, 1);

    left = 6'd3;
    bor = 1; step();
    chk("R6 underflow set", tx_underflow, 1);
    host_write(8'h55);
    chk("R6 write clears underflow", tx_underflow, 0);

    host_write(8'h56);
    cfg(16'h0040);
    chk("R9 clear tx empties", bus_out_valid, 0);
    chk("R10 depth code", buf_status[15:14], 1);

    // random mix
    for (int n = 0; n < 3000; n++) begin
      int r;
      r = int'($urandom_range(0, 99));
      hw  = ($urandom_range(0, 3) == 0);
      hwd = 8'($urandom);
      hr  = ($urandom_range(0, 3) == 0);
      biv = ($urandom_range(0, 2) == 0);
      bid = 8'($urandom);
      bor = ($urandom_range(0, 2) == 0);
      left = 6'($urandom_range(0, 7));
      if (r < 3) begin
        cwe = 1;
        cwd = 16'($urandom);
      end else if (r < 6) begin
        cwe = 1;
        cwd = {2'b00, 6'($urandom_range(0, 20)), 2'b00, 6'($urandom_range(0, 7))};
      end
      step();
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule